// File: doc/BRIEF.md
# Strobed Byte Port (asynchronous parallel FIFO, device side)

This block is the device end of a byte-wide parallel link driven by an external microcontroller. The host pulls active-low strobes to move bytes. A read strobe takes the next byte from a receive queue that on-chip logic fills. A write strobe puts the byte on the shared bus into a transmit queue that on-chip logic drains. The block drives two active-low handshake flags back to the host, "a byte can be read" and "a byte can be written", and it drives an output enable for the shared bus.

The strobes are asynchronous to the block. A synchronizer chain samples them on the system clock and an edge detector turns them into single-cycle events. Each flag works as a handshake. It goes high on every strobe of its direction and stays high for the whole strobe. After the strobe ends, the queue state is checked again before the flag can return low. A strobe that arrives while its flag is high has no effect.

Top module: `strobed_byte_port`

## Requirements
- R1: While reset is held, both flags are high and the bus enable is low. Once reset is released and no strobe is active, the receive flag is high (empty queue) and the transmit flag is low (free space).
- R2: When no strobe is active, the receive flag `hostRxReadyN` is low exactly when the receive queue holds at least one byte.
- R3: A read strobe with the receive flag low drives the oldest queued byte on `hostDataOut` and raises `hostDataOe`. The enable stays high only until the strobe is seen high again. Bytes come out in the order they were pushed.
- R4: The receive flag is high throughout every read strobe and for at least one cycle after it ends. It returns low only if another byte is waiting.
- R5: A read strobe issued while the receive flag is high removes no byte and leaves `hostDataOe` low.
- R6: A write strobe with the transmit flag low stores the `hostDataIn` byte in the transmit queue. Stored bytes appear on `txPopData` in write order.
- R7: The transmit flag is high throughout every write strobe. After the strobe it returns low only if the transmit queue still has room.
- R8: A write strobe issued while the transmit flag is high (queue full) is dropped and stores nothing.
- R9: `rxPushReady` is high exactly when the receive queue is not full, and a push offered while it is low is discarded. `txPopValid` is high exactly when the transmit queue holds data.
- R10: With the default two-stage synchronizer, a strobe falling edge takes effect (flag high, and for a valid read the bus enabled) on the third rising clock edge after the strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostDataIn | input | DATA_W | Bus value seen by the block, captured on a write |
| hostDataOut | output | DATA_W | Byte presented to the host during a read |
| hostDataOe | output | 1 | Tristate enable for `hostDataOut` |
| hostRxReadyN | output | 1 | Low when a byte can be read |
| hostTxRoomN | output | 1 | Low when a byte can be written |
| rxPushValid | input | 1 | On-chip push into the receive queue |
| rxPushData | input | DATA_W | Byte pushed into the receive queue |
| rxPushReady | output | 1 | Receive queue not full |
| txPopValid | output | 1 | Transmit queue holds data |
| txPopData | output | DATA_W | Oldest byte in the transmit queue |
| txPopReady | input | 1 | On-chip pop from the transmit queue |

## Verification
The hardest states to reach are strobes that land while the matching flag is high. These are a read with an empty receive queue and a write with a full transmit queue. Both need the queue to be driven to its limit from the on-chip side first. Directed sequences build these states. They fill the transmit queue with on-chip draining held off, then issue one more write, and they issue reads on an empty queue. A fixed-seed random mix of host strobes and on-chip pushes and pops then crosses these states again, checked against queue models kept in the bench.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic driveBus;
  } portCtrl_t;

  // Queue status from the datapath to the control module.
  typedef struct packed {
    logic rxEmpty;
    logic txFull;
  } portStat_t;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_BUSY   = 2'd1,
    HS_SETTLE = 2'd2
  } hsState_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncN,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= asyncN;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= chain[STAGES-1];
  end

  assign fell = prevLevel & ~chain[STAGES-1];
  assign rose = ~prevLevel & chain[STAGES-1];
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import sbp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic fell,
  input  logic rose,
  input  logic blocked,
  output logic flagN,
  output logic fire
);
  hsState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= HS_IDLE;
      flagN <= 1'b1;
    end else begin
      case (state)
        HS_IDLE: begin
          if (fell) begin
            state <= HS_BUSY;
            flagN <= 1'b1;
          end else begin
            flagN <= blocked;
          end
        end
        HS_BUSY: begin
          flagN <= 1'b1;
          if (rose) state <= HS_SETTLE;
        end
        HS_SETTLE: begin
          flagN <= 1'b1;
          if (fell) state <= HS_BUSY;
          else      state <= HS_IDLE;
        end
        default: begin
          state <= HS_IDLE;
          flagN <= 1'b1;
        end
      endcase
    end
  end

  assign fire = fell && (state == HS_IDLE) && !flagN;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr;
  logic [AW:0]      rdPtr;
  logic             doPush;
  logic             doPop;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headData = mem[rdPtr[AW-1:0]];
endmodule

// File: rtl/port_control.sv
module port_control
  import sbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostRdN,
  input  logic      hostWrN,
  input  portStat_t stat,
  output portCtrl_t ctrl,
  output logic      rxFlagN,
  output logic      txFlagN
);
  logic rdFell, rdRose, wrFell, wrRose;
  logic rxFire, txFire;
  logic driveBus;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_rdSync (
    .clk(clk), .rstN(rstN), .asyncN(hostRdN), .fell(rdFell), .rose(rdRose)
  );

  strobe_sync #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(clk), .rstN(rstN), .asyncN(hostWrN), .fell(wrFell), .rose(wrRose)
  );

  hs_fsm u_rxHs (
    .clk(clk), .rstN(rstN), .fell(rdFell), .rose(rdRose),
    .blocked(stat.rxEmpty), .flagN(rxFlagN), .fire(rxFire)
  );

  hs_fsm u_txHs (
    .clk(clk), .rstN(rstN), .fell(wrFell), .rose(wrRose),
    .blocked(stat.txFull), .flagN(txFlagN), .fire(txFire)
  );

  // The bus is driven only after a granted read, until the strobe rises.
  always_ff @(posedge clk) begin
    if (!rstN)       driveBus <= 1'b0;
    else if (rxFire) driveBus <= 1'b1;
    else if (rdRose) driveBus <= 1'b0;
  end

  assign ctrl.rxPop    = rxFire;
  assign ctrl.txPush   = txFire;
  assign ctrl.driveBus = driveBus;
endmodule

// File: rtl/port_datapath.sv
module port_datapath
  import sbp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCtrl_t         ctrl,
  output portStat_t         stat,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic              rxPushValid,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              rxPushReady,
  output logic              txPopValid,
  output logic [DATA_W-1:0] txPopData,
  input  logic              txPopReady
);
  logic [DATA_W-1:0] rxHead;
  logic              rxEmpty, rxFull, txEmpty, txFull;
  logic [DATA_W-1:0] outReg;

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .pushEn(rxPushValid), .pushData(rxPushData),
    .popEn(ctrl.rxPop), .headData(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .pushEn(ctrl.txPush), .pushData(hostDataIn),
    .popEn(txPopReady), .headData(txPopData),
    .empty(txEmpty), .full(txFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN)           outReg <= '0;
    else if (ctrl.rxPop) outReg <= rxHead;
  end

  assign hostDataOut  = outReg;
  assign hostDataOe   = ctrl.driveBus;
  assign rxPushReady  = !rxFull;
  assign txPopValid   = !txEmpty;
  assign stat.rxEmpty = rxEmpty;
  assign stat.txFull  = txFull;
endmodule

// File: rtl/strobed_byte_port.sv
module strobed_byte_port
  import sbp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostRxReadyN,
  output logic              hostTxRoomN,
  input  logic              rxPushValid,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              rxPushReady,
  output logic              txPopValid,
  output logic [DATA_W-1:0] txPopData,
  input  logic              txPopReady
);
  portCtrl_t ctrl;
  portStat_t stat;

  port_control #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk(clk), .rstN(rstN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .stat(stat), .ctrl(ctrl), .rxFlagN(hostRxReadyN), .txFlagN(hostTxRoomN)
  );

  port_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stat(stat),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData), .rxPushReady(rxPushReady),
    .txPopValid(txPopValid), .txPopData(txPopData), .txPopReady(txPopReady)
  );
endmodule

// File: rtl/strobed_byte_port_checker.sv
module strobed_byte_port_checker (
  input logic clk,
  input logic rstN,
  input logic hostDataOe,
  input logic hostRxReadyN,
  input logic hostTxRoomN,
  input logic rxPop,
  input logic txPush,
  input logic rxEmpty,
  input logic txFull
);
  // R5: a granted read never removes a byte from an empty queue
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> !rxEmpty);

  // R8: a write is never stored into a full queue
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> !txFull);

  // R3: the bus is only driven while the receive flag is high
  a_r3_oe_flag_high: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> hostRxReadyN);

  // R3: the bus enable only rises out of a cycle where a byte was offered
  a_r3_oe_after_offer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostDataOe) |-> !$past(hostRxReadyN));

  // R4: the receive flag falls only when the queue held data
  a_r4_flag_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRxReadyN) |-> !$past(rxEmpty));

  // R7: the transmit flag is low only while the queue has room
  a_r7_room_flag: assert property (@(posedge clk) disable iff (!rstN)
    !hostTxRoomN |-> !txFull);
endmodule

bind strobed_byte_port strobed_byte_port_checker u_checker (
  .clk(clk),
  .rstN(rstN),
  .hostDataOe(hostDataOe),
  .hostRxReadyN(hostRxReadyN),
  .hostTxRoomN(hostTxRoomN),
  .rxPop(ctrl.rxPop),
  .txPush(ctrl.txPush),
  .rxEmpty(stat.rxEmpty),
  .txFull(stat.txFull)
);

// File: tb/strobed_byte_port_bench.sv
`timescale 1ns/1ps
module strobed_byte_port_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostRdN = 1'b1;
  logic          hostWrN = 1'b1;
  logic [DW-1:0] hostDataIn = '0;
  logic [DW-1:0] hostDataOut;
  logic          hostDataOe;
  logic          hostRxReadyN;
  logic          hostTxRoomN;
  logic          rxPushValid = 1'b0;
  logic [DW-1:0] rxPushData = '0;
  logic          rxPushReady;
  logic          txPopValid;
  logic [DW-1:0] txPopData;
  logic          txPopReady = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [DW-1:0] rxModel[$];
  logic [DW-1:0] txModel[$];

  always #5 clk = ~clk;

  strobed_byte_port #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_strobed_byte_port (
    .clk(clk), .rstN(rstN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .hostRxReadyN(hostRxReadyN), .hostTxRoomN(hostTxRoomN),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData), .rxPushReady(rxPushReady),
    .txPopValid(txPopValid), .txPopData(txPopData), .txPopReady(txPopReady)
  );

  function automatic logic expRxFlag(input int count);
    return (count == 0);
  endfunction

  function automatic logic expTxFlag(input int count);
    return (count >= DEPTH);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hostRead();
    bit valid;
    logic [DW-1:0] expByte;
    waitCycles(6);
    chk(hostRxReadyN == expRxFlag(rxModel.size()), "R2 rx flag idle", hostRxReadyN, expRxFlag(rxModel.size()));
    valid = !hostRxReadyN;
    expByte = (rxModel.size() > 0) ? rxModel[0] : '0;
    hostRdN = 1'b0;
    waitCycles(3);
    chk(hostRxReadyN == 1'b1, "R10 R4 rx flag high in strobe", hostRxReadyN, 1);
    chk(hostDataOe == valid, "R10 R3 R5 bus enable in strobe", hostDataOe, valid);
    if (valid) begin
      chk(hostDataOut == expByte, "R3 read byte order", hostDataOut, expByte);
      void'(rxModel.pop_front());
    end
    waitCycles(2);
    hostRdN = 1'b1;
    waitCycles(2);
    chk(hostRxReadyN == 1'b1, "R4 rx flag high after strobe", hostRxReadyN, 1);
    waitCycles(2);
    chk(hostDataOe == 1'b0, "R3 bus released", hostDataOe, 0);
  endtask

  task automatic hostWrite(input logic [DW-1:0] b);
    bit valid;
    waitCycles(6);
    chk(hostTxRoomN == expTxFlag(txModel.size()), "R7 tx flag idle", hostTxRoomN, expTxFlag(txModel.size()));
    valid = !hostTxRoomN;
    hostDataIn = b;
    hostWrN = 1'b0;
    waitCycles(3);
    chk(hostTxRoomN == 1'b1, "R10 R7 tx flag high in strobe", hostTxRoomN, 1);
    if (valid) txModel.push_back(b);
    waitCycles(2);
    hostWrN = 1'b1;
    waitCycles(1);
    hostDataIn = DW'($urandom);
    waitCycles(6);
    chk(hostTxRoomN == expTxFlag(txModel.size()), "R7 R8 tx flag after strobe", hostTxRoomN, expTxFlag(txModel.size()));
  endtask

  task automatic devPush(input logic [DW-1:0] b);
    bit room;
    room = rxModel.size() < DEPTH;
    rxPushValid = 1'b1;
    rxPushData = b;
    chk(rxPushReady == room, "R9 push ready", rxPushReady, room);
    if (room) rxModel.push_back(b);
    waitCycles(1);
    rxPushValid = 1'b0;
  endtask

  task automatic devPop();
    bit has;
    has = txModel.size() > 0;
    chk(txPopValid == has, "R9 pop valid", txPopValid, has);
    if (has) begin
      chk(txPopData == txModel[0], "R6 R8 tx byte order", txPopData, txModel[0]);
      void'(txModel.pop_front());
    end
    txPopReady = 1'b1;
    waitCycles(1);
    txPopReady = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int sel;
    void'($urandom(32'd20240517));
    waitCycles(4);
    chk(hostRxReadyN == 1'b1, "R1 rx flag in reset", hostRxReadyN, 1);
    chk(hostTxRoomN == 1'b1, "R1 tx flag in reset", hostTxRoomN, 1);
    chk(hostDataOe == 1'b0, "R1 bus enable in reset", hostDataOe, 0);
    rstN = 1'b1;
    waitCycles(4);
    chk(hostRxReadyN == 1'b1, "R1 rx flag after reset", hostRxReadyN, 1);
    chk(hostTxRoomN == 1'b0, "R1 tx flag after reset", hostTxRoomN, 0);

    // R5: read on empty queue
    hostRead();
    // R3/R2: ordered reads
    devPush(8'hA5); devPush(8'h3C); devPush(8'hFF);
    hostRead(); hostRead(); hostRead();
    hostRead();
    // R9: overfill receive queue
    for (int i = 0; i < DEPTH + 2; i++) devPush(DW'(i * 17 + 1));
    for (int i = 0; i < DEPTH + 1; i++) hostRead();
    // R8: overfill transmit queue, then drain
    for (int i = 0; i < DEPTH + 2; i++) hostWrite(DW'(8'h40 + i));
    for (int i = 0; i < DEPTH + 1; i++) devPop();
    hostWrite(8'h00);
    hostWrite(8'hFF);
    devPop(); devPop();

    // Random mix
    for (int n = 0; n < 400; n++) begin
      sel = int'($urandom_range(0, 3));
      case (sel)
        0: devPush(DW'($urandom));
        1: hostRead();
        2: hostWrite(DW'($urandom));
        default: devPop();
      endcase
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule